// File: doc/BRIEF.md
# Checkpointed Multi-Port Register File

This block is a 64-entry integer register file for a wide in-order execution core. The low part of the file holds guest architectural state, and each register in that part has two copies: a working copy that execution writes, and a shadow copy that holds the last checkpoint. The upper part holds scratch and internal values. It is a plain register file with no shadow.

Four write ports and eight read ports serve the issue slots. Two strobes control the checkpoint. A commit strobe copies the whole shadowed working state into the shadows in the cycle it is raised, so a checkpoint costs no extra cycle. A rollback strobe puts the last checkpoint back into the shadowed working registers in one cycle. Software that decides when to commit or roll back sits outside the block.

Read data is registered. The address presented in a cycle returns, after the next rising edge, the working value as it stands after that edge. This includes any write made in the same cycle as the read.

Top module: `shadow_regfile`

## Requirements
- R1: A synchronous active-high reset clears every working copy, every shadow copy and every read output to zero.
- R2: A read address presented in cycle t shows on its read data after edge t. It returns the working value after that edge, including a write to the same register in cycle t.
- R3: Ordinary writes never change a shadow copy. A rollback after writes returns each shadowed register to its value at the last commit.
- R4: While commit is high and rollback is low, every shadowed register's shadow takes its working value at that edge. A write landing in the same cycle is part of the committed value.
- R5: A rollback restores every shadowed register (indices 0 to NSHADOW-1, default 0 to 31) from its shadow in a single cycle. Before any commit, the shadow holds zero after reset.
- R6: A write to a shadowed register in the same cycle as a rollback is discarded.
- R7: When commit and rollback are high together, rollback is performed and commit is ignored, so the shadows keep their previous values.
- R8: Registers NSHADOW to 63 have no shadow. Rollback and commit do not change them, and writes to them land even in a rollback cycle.
- R9: When several write ports target the same register in one cycle, the highest-numbered enabled port wins. Writes to distinct registers all land.
- R10: The eight read ports are independent, and each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 4 | Write enable per write port |
| wr_addr | input | 4x6 | Register index per write port |
| wr_data | input | 4x32 | Write data per write port |
| rd_addr | input | 8x6 | Register index per read port |
| rd_data | output | 8x32 | Registered read data per read port |
| commit | input | 1 | Copy shadowed working state into the shadows |
| rollback | input | 1 | Restore shadowed working state from the shadows |

## Verification
Three pairs of functions can fall in the same cycle: commit with a write, rollback with a write, and commit with rollback. The bench raises each pair together on registers whose shadow and working values differ. It judges the outcome from a later read or a later rollback. A write that joins a commit must come back after the next rollback. A write that meets a rollback must be gone on a shadowed index and present on an unshadowed one. A commit that meets a rollback must leave the earlier checkpoint in place, so a second rollback still returns that checkpoint.

// File: rtl/srf_pkg.sv
package srf_pkg;
  // Checkpoint action decoded from the two strobes; rollback outranks commit.
  typedef enum logic [1:0] {
    CKPT_NONE     = 2'd0,
    CKPT_COMMIT   = 2'd1,
    CKPT_ROLLBACK = 2'd2
  } ckpt_op_e;

  function automatic ckpt_op_e decode_ckpt(input logic cm, input logic rb);
    if (rb)      return CKPT_ROLLBACK;
    else if (cm) return CKPT_COMMIT;
    else         return CKPT_NONE;
  endfunction
endpackage

// File: rtl/srf_write_merge.sv
module srf_write_merge #(
  parameter int NREG = 64,
  parameter int NWR  = 4,
  parameter int XLEN = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic [NWR-1:0]            wr_en,
  input  logic [NWR-1:0][AW-1:0]    wr_addr,
  input  logic [NWR-1:0][XLEN-1:0]  wr_data,
  output logic [NREG-1:0]           hit,
  output logic [NREG-1:0][XLEN-1:0] hit_data
);
  // Ascending slot walk: a later (higher) slot overrides an earlier one.
  always_comb begin
    hit      = '0;
    hit_data = '0;
    for (int s = 0; s < NWR; s++) begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en[s] && (wr_addr[s] == AW'(r))) begin
          hit[r]      = 1'b1;
          hit_data[r] = wr_data[s];
        end
      end
    end
  end
endmodule

// File: rtl/srf_shadow_bank.sv
module srf_shadow_bank #(
  parameter int NSH  = 32,
  parameter int XLEN = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     commit_en,
  input  logic [NSH-1:0][XLEN-1:0] din,
  output logic [NSH-1:0][XLEN-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)            dout <= '0;
    else if (commit_en) dout <= din;
  end

  // R3: outside a commit the checkpoint is frozen
  p_shadow_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !commit_en |=> $stable(dout));
endmodule

// File: rtl/srf_read_port.sv
module srf_read_port #(
  parameter int NREG = 64,
  parameter int XLEN = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             addr,
  input  logic [NREG-1:0][XLEN-1:0] state_next,
  output logic [XLEN-1:0]           data
);
  // Selecting from the next-state vector gives same-cycle write bypass.
  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= state_next[addr];
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int NREG    = 64,
  parameter int NSHADOW = 32,
  parameter int XLEN    = 32,
  parameter int NWR     = 4,
  parameter int NRD     = 8,
  localparam int AW     = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NWR-1:0]            wr_en,
  input  logic [NWR-1:0][AW-1:0]    wr_addr,
  input  logic [NWR-1:0][XLEN-1:0]  wr_data,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][XLEN-1:0]  rd_data,
  input  logic                      commit,
  input  logic                      rollback
);
  import srf_pkg::*;

  ckpt_op_e                      op;
  logic [NREG-1:0]               hit;
  logic [NREG-1:0][XLEN-1:0]     hit_data;
  logic [NREG-1:0][XLEN-1:0]     work_q;
  logic [NREG-1:0][XLEN-1:0]     work_d;
  logic [NSHADOW-1:0][XLEN-1:0]  shadow_q;

  assign op = decode_ckpt(commit, rollback);

  srf_write_merge #(.NREG(NREG), .NWR(NWR), .XLEN(XLEN)) u_merge (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit(hit), .hit_data(hit_data)
  );

  // Next working state: shadowed entries take the shadow on rollback,
  // otherwise every entry takes its winning write or holds.
  for (genvar g = 0; g < NREG; g++) begin : g_next
    if (g < NSHADOW) begin : g_shadowed
      always_comb begin
        if (op == CKPT_ROLLBACK) work_d[g] = shadow_q[g];
        else if (hit[g])         work_d[g] = hit_data[g];
        else                     work_d[g] = work_q[g];
      end
    end else begin : g_plain
      always_comb begin
        if (hit[g]) work_d[g] = hit_data[g];
        else        work_d[g] = work_q[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) work_q <= '0;
    else     work_q <= work_d;
  end

  // Commit captures the next working state, so same-cycle writes are included.
  srf_shadow_bank #(.NSH(NSHADOW), .XLEN(XLEN)) u_shadow (
    .clk(clk), .rst(rst),
    .commit_en(op == CKPT_COMMIT),
    .din(work_d[NSHADOW-1:0]),
    .dout(shadow_q)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    srf_read_port #(.NREG(NREG), .XLEN(XLEN)) u_port (
      .clk(clk), .rst(rst), .addr(rd_addr[p]),
      .state_next(work_d), .data(rd_data[p])
    );

    // R2/R10: each port shows the working copy of its own register
    p_read_working_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> rd_data[p] == work_q[$past(rd_addr[p])]);
  end

  // R4: after a commit the checkpoint equals the shadowed working state
  p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (commit && !rollback) |=> shadow_q == work_q[NSHADOW-1:0]);

  // R5/R6: after a rollback the shadowed working state equals the old checkpoint
  p_rollback_restore_r5: assert property (@(posedge clk) disable iff (rst)
    rollback |=> work_q[NSHADOW-1:0] == $past(shadow_q));

  // R7: a commit that meets a rollback leaves the checkpoint untouched
  p_rollback_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (commit && rollback) |=> $stable(shadow_q));

  // R8: with no writes, a rollback leaves the unshadowed part alone
  p_plain_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (rollback && !(|wr_en)) |=> $stable(work_q[NREG-1:NSHADOW]));

  // R9: the highest enabled port owns its target register
  p_top_slot_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en[NWR-1] && !rollback) |=> work_q[$past(wr_addr[NWR-1])] == $past(wr_data[NWR-1]));
endmodule

// File: tb/shadow_regfile_test.sv
module shadow_regfile_test;
  localparam int NWR = 4;
  localparam int NRD = 8;
  localparam int NT  = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NWR-1:0]        wr_en;
  logic [NWR-1:0][5:0]   wr_addr;
  logic [NWR-1:0][31:0]  wr_data;
  logic [NRD-1:0][5:0]   rd_addr;
  logic [NRD-1:0][31:0]  rd_data;
  logic commit, rollback;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  shadow_regfile uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .commit(commit), .rollback(rollback)
  );

  // {op[2:0] = {rollback, commit, write on port 0}, wr idx, wr data, rd idx, expected}
  localparam logic [78:0] TBL [0:NT-1] = '{
    {3'b001, 6'd5,  32'hA1A1_0001, 6'd5,  32'hA1A1_0001},  // R2 bypass
    {3'b001, 6'd40, 32'hB1B1_0001, 6'd40, 32'hB1B1_0001},  // R2
    {3'b010, 6'd0,  32'h0,         6'd5,  32'hA1A1_0001},  // R4 commit
    {3'b001, 6'd5,  32'hA1A1_0002, 6'd5,  32'hA1A1_0002},  // R3 write
    {3'b100, 6'd0,  32'h0,         6'd5,  32'hA1A1_0001},  // R3 R5 restore
    {3'b011, 6'd7,  32'hC1C1_0001, 6'd7,  32'hC1C1_0001},  // R4 write+commit
    {3'b001, 6'd7,  32'hC1C1_0002, 6'd7,  32'hC1C1_0002},  // R2
    {3'b100, 6'd0,  32'h0,         6'd7,  32'hC1C1_0001},  // R4 write was committed
    {3'b101, 6'd9,  32'hD1D1_0001, 6'd9,  32'h0},          // R6 discarded
    {3'b001, 6'd40, 32'hB1B1_0002, 6'd40, 32'hB1B1_0002},  // R2
    {3'b101, 6'd41, 32'hE1E1_0001, 6'd41, 32'hE1E1_0001},  // R8 lands in rollback
    {3'b100, 6'd0,  32'h0,         6'd40, 32'hB1B1_0002},  // R8 kept
    {3'b001, 6'd5,  32'hA1A1_0004, 6'd5,  32'hA1A1_0004},  // R2
    {3'b110, 6'd0,  32'h0,         6'd5,  32'hA1A1_0001},  // R7 rollback wins
    {3'b001, 6'd5,  32'hA1A1_0005, 6'd5,  32'hA1A1_0005},  // R2
    {3'b100, 6'd0,  32'h0,         6'd5,  32'hA1A1_0001},  // R7 commit ignored
    {3'b011, 6'd40, 32'hB1B1_0003, 6'd40, 32'hB1B1_0003},  // R8
    {3'b100, 6'd0,  32'h0,         6'd40, 32'hB1B1_0003},  // R8 no shadow
    {3'b001, 6'd31, 32'h3131_0001, 6'd31, 32'h3131_0001},  // R2 top shadowed
    {3'b001, 6'd32, 32'h3232_0001, 6'd32, 32'h3232_0001},  // R2 first plain
    {3'b100, 6'd0,  32'h0,         6'd31, 32'h0},          // R5 boundary
    {3'b000, 6'd0,  32'h0,         6'd32, 32'h3232_0001}   // R8 boundary
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = '0; wr_addr = '0; wr_data = '0;
    commit = 1'b0; rollback = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state on all read ports, and an early rollback yields zero
    for (int p = 0; p < NRD; p++) rd_addr[p] = 6'(p * 9);
    rollback = 1'b1;
    tick();
    for (int p = 0; p < NRD; p++) check("R1", rd_data[p], 32'h0);
    idle();

    // Vector walk on port 0
    for (int i = 0; i < NT; i++) begin
      wr_en[0]   = TBL[i][76];
      commit     = TBL[i][77];
      rollback   = TBL[i][78];
      wr_addr[0] = TBL[i][75:70];
      wr_data[0] = TBL[i][69:38];
      rd_addr[0] = TBL[i][37:32];
      tick();
      check($sformatf("vector %0d", i), rd_data[0], TBL[i][31:0]);
      idle();
    end

    // R9: all four ports hit register 3, the highest port wins
    rd_addr[0] = 6'd3;
    for (int s = 0; s < NWR; s++) begin
      wr_en[s] = 1'b1; wr_addr[s] = 6'd3; wr_data[s] = 32'h9000_0000 + 32'(s);
    end
    tick();
    check("R9", rd_data[0], 32'h9000_0003);
    idle();
    // R9: ports 0..2 on register 3, port 2 wins
    for (int s = 0; s < 3; s++) begin
      wr_en[s] = 1'b1; wr_addr[s] = 6'd3; wr_data[s] = 32'h9100_0000 + 32'(s);
    end
    tick();
    check("R9", rd_data[0], 32'h9100_0002);
    idle();

    // R10: fill eight registers through four ports over two cycles, read all at once
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < NWR; s++) begin
        wr_en[s]   = 1'b1;
        wr_addr[s] = 6'((c * NWR + s) * 7 + 2);
        wr_data[s] = 32'h5A00_0000 + 32'(c * NWR + s);
      end
      tick();
      idle();
    end
    for (int p = 0; p < NRD; p++) rd_addr[p] = 6'(p * 7 + 2);
    tick();
    for (int p = 0; p < NRD; p++) check("R10", rd_data[p], 32'h5A00_0000 + 32'(p));

    // R1: reset mid-run clears working and shadow copies
    commit = 1'b1;
    tick();
    idle();
    rst = 1'b1;
    tick();
    rst = 1'b0;
    for (int p = 0; p < NRD; p++) check("R1", rd_data[p], 32'h0);
    rollback = 1'b1;
    tick();
    idle();
    for (int p = 0; p < NRD; p++) check("R1", rd_data[p], 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule